// File: doc/BRIEF.md
# Circular-Buffer Data Address Generator

This block produces data-memory addresses for a signal-processing core that reads and writes through pointers. It keeps four 16-bit index pointers, four modify values, and for each pointer a base and a length that describe a circular buffer. When an access is requested, the caller names one pointer and one modify value. The block then forms an address and advances the chosen pointer by the modify value. If that pointer's length is nonzero, the step wraps so that the pointer stays inside its buffer.

An 8-bit page value is placed above the 16-bit pointer to form a 24-bit address. Wrapping acts only on the pointer, so a buffer never spans two pages. Each access chooses pre-modify or post-modify. With pre-modify, the stepped pointer is the address. With post-modify, the old pointer is the address and the stepped value is stored.

All registers exist twice, in two banks. A bank-select input picks the active bank, which allows a context switch in one cycle. Software loads registers through a write port and reads the active bank through a readback port.

Top module: `circ_addr_gen`

## Requirements
- R1: A synchronous active-high `rst` clears every register in both banks and makes bank 0 active. After reset, every readback is 0 and an access to pointer 0 yields address 0.
- R2: With `acc_pre`=0 (post-modify), `addr_out[15:0]` is the current pointer value. At the clock edge the pointer takes the stepped value.
- R3: With `acc_pre`=1 (pre-modify), `addr_out[15:0]` is the stepped value. At the clock edge the pointer takes that same value.
- R4: When the pointer's length is 0, the stepped value is the pointer plus the modify value, truncated to 16 bits. Modify values are signed two's complement.
- R5: When the length L is nonzero and the modify value is non-negative, a sum at or above base+L is reduced by L.
- R6: When the length L is nonzero and the modify value is negative, a sum below base is raised by L.
- R7: `addr_out[23:16]` always equals the active page register. Stepping or wrapping the pointer never changes the page.
- R8: If a register write to index register k and an access that updates pointer k fall in the same cycle, the written value is stored.
- R9: `bank_sel` becomes the active bank at the next rising edge. Writes and updates act only on the active bank, and the inactive bank keeps its contents.
- R10: `rd_data` returns the register of the active bank chosen by `rd_kind` and `rd_sel`. The same codes select the target of a write: 0 index, 1 modify, 2 length, 3 base, 4 page. The page is zero-extended on readback and taken from `wr_data[7:0]` on write, with `wr_sel` ignored.
- R11: With `acc_valid`=0, no pointer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request strobe |
| acc_ptr | input | 2 | Pointer used by the access |
| acc_mod | input | 2 | Modify register used by the access |
| acc_pre | input | 1 | 1 = pre-modify, 0 = post-modify |
| addr_out | output | 24 | Page concatenated with the 16-bit address |
| wr_en | input | 1 | Register write strobe |
| wr_kind | input | 3 | Register kind to write (R10 codes) |
| wr_sel | input | 2 | Register number within the kind |
| wr_data | input | 16 | Write value |
| bank_sel | input | 1 | Requested active bank |
| rd_kind | input | 3 | Register kind to read back |
| rd_sel | input | 2 | Register number to read back |
| rd_data | output | 16 | Readback value from the active bank |

## Verification
The in-buffer property assumes two things about every nonzero-length access. The pointer must already lie between base and base+length-1. The magnitude of the modify value must not exceed the length. The stimulus loads each circular pointer inside its buffer before using it. It also keeps every modify value at or below the length of each buffer it steps, including one step exactly equal to the length. The readback properties assume that `rd_kind` and `rd_sel` stay steady while the bench observes them, so the bench changes them only as part of a read.

// File: rtl/cag_pkg.sv
package cag_pkg;
    localparam int CAG_NPTR = 4;
    localparam int CAG_AW   = 16;
    localparam int CAG_PW   = 8;

    typedef enum logic [2:0] {
        RK_INDEX  = 3'd0,
        RK_MODIFY = 3'd1,
        RK_LENGTH = 3'd2,
        RK_BASE   = 3'd3,
        RK_PAGE   = 3'd4
    } reg_kind_e;

    typedef struct packed {
        logic [CAG_AW-1:0] idx;
        logic [CAG_AW-1:0] base;
        logic [CAG_AW-1:0] len;
        logic [CAG_AW-1:0] step;
    } ptr_ctx_t;
endpackage

// File: rtl/cag_wrap.sv
module cag_wrap
    import cag_pkg::*;
#(
    parameter int AW = CAG_AW
) (
    input  logic [AW-1:0] idx,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] step,
    output logic [AW-1:0] nxt
);
    localparam int EW = AW + 2;

    logic signed [EW-1:0] sum;
    logic signed [EW-1:0] lo;
    logic signed [EW-1:0] hi;
    logic signed [EW-1:0] up;
    logic signed [EW-1:0] dn;
    logic                 neg;

    always_comb begin
        neg = step[AW-1];
        sum = $signed({2'b00, idx}) + $signed({{2{step[AW-1]}}, step});
        lo  = $signed({2'b00, base});
        hi  = lo + $signed({2'b00, len});
        up  = sum + $signed({2'b00, len});
        dn  = sum - $signed({2'b00, len});
        if (len == '0) begin
            nxt = sum[AW-1:0];
        end else if (neg && (sum < lo)) begin
            nxt = up[AW-1:0];
        end else if (!neg && (sum >= hi)) begin
            nxt = dn[AW-1:0];
        end else begin
            nxt = sum[AW-1:0];
        end
    end
endmodule

// File: rtl/cag_regbank.sv
module cag_regbank
    import cag_pkg::*;
#(
    parameter int NPTR = CAG_NPTR,
    parameter int AW   = CAG_AW,
    parameter int PW   = CAG_PW,
    localparam int PSW = $clog2(NPTR)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  logic [2:0]               wkind,
    input  logic [PSW-1:0]           wsel,
    input  logic [AW-1:0]            wdata,
    input  logic [PW-1:0]            wpage,
    input  logic                     ue,
    input  logic [PSW-1:0]           usel,
    input  logic [AW-1:0]            uval,
    output logic [NPTR-1:0][AW-1:0]  idx_q,
    output logic [NPTR-1:0][AW-1:0]  mod_q,
    output logic [NPTR-1:0][AW-1:0]  len_q,
    output logic [NPTR-1:0][AW-1:0]  base_q,
    output logic [PW-1:0]            page_q
);
    for (genvar i = 0; i < NPTR; i++) begin : g_slot
        logic [AW-1:0] r_idx, r_mod, r_len, r_base;
        logic          hit;

        assign hit = we && (wsel == PSW'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                r_idx  <= '0;
                r_mod  <= '0;
                r_len  <= '0;
                r_base <= '0;
            end else begin
                if (hit && (wkind == RK_INDEX)) r_idx <= wdata;
                else if (ue && (usel == PSW'(i))) r_idx <= uval;
                if (hit && (wkind == RK_MODIFY)) r_mod  <= wdata;
                if (hit && (wkind == RK_LENGTH)) r_len  <= wdata;
                if (hit && (wkind == RK_BASE))   r_base <= wdata;
            end
        end

        assign idx_q[i]  = r_idx;
        assign mod_q[i]  = r_mod;
        assign len_q[i]  = r_len;
        assign base_q[i] = r_base;
    end

    always_ff @(posedge clk) begin
        if (rst)                          page_q <= '0;
        else if (we && wkind == RK_PAGE)  page_q <= wpage;
    end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
    import cag_pkg::*;
#(
    parameter int NPTR = CAG_NPTR,
    parameter int AW   = CAG_AW,
    parameter int PW   = CAG_PW,
    localparam int PSW = $clog2(NPTR),
    localparam int FW  = PW + AW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           acc_valid,
    input  logic [PSW-1:0] acc_ptr,
    input  logic [PSW-1:0] acc_mod,
    input  logic           acc_pre,
    output logic [FW-1:0]  addr_out,
    input  logic           wr_en,
    input  logic [2:0]     wr_kind,
    input  logic [PSW-1:0] wr_sel,
    input  logic [AW-1:0]  wr_data,
    input  logic           bank_sel,
    input  logic [2:0]     rd_kind,
    input  logic [PSW-1:0] rd_sel,
    output logic [AW-1:0]  rd_data
);
    localparam int NBANK = 2;

    logic                    bank_q;
    logic [NPTR-1:0][AW-1:0] b_idx  [NBANK];
    logic [NPTR-1:0][AW-1:0] b_mod  [NBANK];
    logic [NPTR-1:0][AW-1:0] b_len  [NBANK];
    logic [NPTR-1:0][AW-1:0] b_base [NBANK];
    logic [PW-1:0]           b_page [NBANK];

    ptr_ctx_t      ctx;
    logic [AW-1:0] upd_val;
    logic [PW-1:0] cur_page;

    always_ff @(posedge clk) begin
        if (rst) bank_q <= 1'b0;
        else     bank_q <= bank_sel;
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic act;
        assign act = (bank_q == 1'(b));
        cag_regbank #(.NPTR(NPTR), .AW(AW), .PW(PW)) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_en && act),
            .wkind (wr_kind),
            .wsel  (wr_sel),
            .wdata (wr_data),
            .wpage (wr_data[PW-1:0]),
            .ue    (acc_valid && act),
            .usel  (acc_ptr),
            .uval  (upd_val),
            .idx_q (b_idx[b]),
            .mod_q (b_mod[b]),
            .len_q (b_len[b]),
            .base_q(b_base[b]),
            .page_q(b_page[b])
        );
    end

    always_comb begin
        ctx.idx  = b_idx[bank_q][acc_ptr];
        ctx.base = b_base[bank_q][acc_ptr];
        ctx.len  = b_len[bank_q][acc_ptr];
        ctx.step = b_mod[bank_q][acc_mod];
        cur_page = b_page[bank_q];
    end

    cag_wrap #(.AW(AW)) u_wrap (
        .idx (ctx.idx),
        .base(ctx.base),
        .len (ctx.len),
        .step(ctx.step),
        .nxt (upd_val)
    );

    assign addr_out = {cur_page, (acc_pre ? upd_val : ctx.idx)};

    always_comb begin
        case (rd_kind)
            RK_INDEX:  rd_data = b_idx[bank_q][rd_sel];
            RK_MODIFY: rd_data = b_mod[bank_q][rd_sel];
            RK_LENGTH: rd_data = b_len[bank_q][rd_sel];
            RK_BASE:   rd_data = b_base[bank_q][rd_sel];
            RK_PAGE:   rd_data = AW'(cur_page);
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cag_checker.sv
module cag_checker #(
    parameter int AW  = 16,
    parameter int PW  = 8,
    parameter int PSW = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           acc_valid,
    input logic           acc_pre,
    input logic [PSW-1:0] acc_ptr,
    input logic [PW+AW-1:0] addr_out,
    input logic           wr_en,
    input logic [2:0]     wr_kind,
    input logic [PSW-1:0] wr_sel,
    input logic [AW-1:0]  wr_data,
    input logic           bank_sel,
    input logic           bank_q,
    input logic [2:0]     rd_kind,
    input logic [PSW-1:0] rd_sel,
    input logic [AW-1:0]  rd_data,
    input logic [AW-1:0]  c_idx,
    input logic [AW-1:0]  c_base,
    input logic [AW-1:0]  c_len,
    input logic [AW-1:0]  c_step,
    input logic [AW-1:0]  upd_val
);
    logic [AW+1:0] lo, hi, idx_e, nv_e;
    logic [AW-1:0] mag;
    logic          in_buf_before, step_ok;

    always_comb begin
        lo    = {2'b00, c_base};
        hi    = lo + {2'b00, c_len};
        idx_e = {2'b00, c_idx};
        nv_e  = {2'b00, upd_val};
        mag   = c_step[AW-1] ? (~c_step + 1'b1) : c_step;
        in_buf_before = (idx_e >= lo) && (idx_e < hi);
        step_ok       = (mag <= c_len);
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

    p_post_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_pre && rd_kind == 3'd0 && rd_sel == acc_ptr)
        |-> (addr_out[AW-1:0] == rd_data));

    p_stay_in_buf_r5: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && c_len != '0 && in_buf_before && step_ok)
        |-> ((nv_e >= lo) && (nv_e < hi)));

    p_page_field_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_kind == 3'd4) |-> (addr_out[PW+AW-1:AW] == rd_data[PW-1:0]));

    p_write_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_kind == 3'd0)
        |=> (!(rd_kind == 3'd0 && rd_sel == $past(wr_sel) && bank_q == $past(bank_q))
             || rd_data == $past(wr_data)));

    p_bank_follow_r9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (bank_q == $past(bank_sel)));

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid && !wr_en && bank_sel == bank_q)
        |=> (!($stable(rd_kind) && $stable(rd_sel)) || $stable(rd_data)));
endmodule

bind circ_addr_gen cag_checker #(.AW(AW), .PW(PW), .PSW(PSW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .acc_valid(acc_valid),
    .acc_pre  (acc_pre),
    .acc_ptr  (acc_ptr),
    .addr_out (addr_out),
    .wr_en    (wr_en),
    .wr_kind  (wr_kind),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .bank_sel (bank_sel),
    .bank_q   (bank_q),
    .rd_kind  (rd_kind),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .c_idx    (ctx.idx),
    .c_base   (ctx.base),
    .c_len    (ctx.len),
    .c_step   (ctx.step),
    .upd_val  (upd_val)
);

// File: tb/sim_circ_addr_gen.sv
module sim_circ_addr_gen;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_ptr = '0;
    logic [1:0]  acc_mod = '0;
    logic        acc_pre = 1'b0;
    logic [23:0] addr_out;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_kind = '0;
    logic [1:0]  wr_sel = '0;
    logic [15:0] wr_data = '0;
    logic        bank_sel = 1'b0;
    logic [2:0]  rd_kind = '0;
    logic [1:0]  rd_sel = '0;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit done = 0;

    circ_addr_gen u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // {ptr, mod, pre, expected address}
    localparam logic [28:0] VEC [NVEC] = '{
        {2'd0, 2'd0, 1'b0, 24'h120100},  // R2
        {2'd0, 2'd0, 1'b0, 24'h120103},  // R2
        {2'd0, 2'd0, 1'b0, 24'h120106},  // R5 wrap follows
        {2'd0, 2'd0, 1'b1, 24'h120104},  // R3
        {2'd0, 2'd1, 1'b1, 24'h120102},  // R3 negative
        {2'd0, 2'd1, 1'b0, 24'h120102},  // R2
        {2'd0, 2'd1, 1'b1, 24'h120106},  // R6
        {2'd1, 2'd2, 1'b0, 24'h12FFFE},  // R4 / R7
        {2'd1, 2'd2, 1'b0, 24'h120003},  // R4 / R7
        {2'd2, 2'd1, 1'b0, 24'h120201},  // R6 wrap follows
        {2'd2, 2'd0, 1'b1, 24'h120202},  // R5
        {2'd3, 2'd1, 1'b1, 24'h12003E},  // R4
        {2'd3, 2'd3, 1'b0, 24'h12003E},  // R2
        {2'd2, 2'd2, 1'b1, 24'h120202}   // R5 step equals length
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] k, input logic [1:0] s, input logic [15:0] d);
        wr_en = 1'b1; wr_kind = k; wr_sel = s; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] k, input logic [1:0] s,
                            input logic [15:0] exp);
        rd_kind = k; rd_sel = s;
        #1;
        check(req, {16'h0, rd_data}, {16'h0, exp});
    endtask

    task automatic access(input string req, input logic [1:0] p, input logic [1:0] m,
                          input logic pre, input logic [23:0] exp);
        acc_valid = 1'b1; acc_ptr = p; acc_mod = m; acc_pre = pre;
        #1;
        check(req, {8'h0, addr_out}, {8'h0, exp});
        @(posedge clk); #1;
        acc_valid = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected<20000", cyc);
            finish_up();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        rd_check("R1 index0", 3'd0, 2'd0, 16'h0);
        rd_check("R1 length3", 3'd2, 2'd3, 16'h0);
        rd_check("R1 page", 3'd4, 2'd0, 16'h0);
        access("R1 first address", 2'd0, 2'd0, 1'b0, 24'h000000);

        // Setup of bank 0
        wreg(3'd4, 2'd0, 16'hAB12);          // page takes low byte only
        wreg(3'd1, 2'd0, 16'h0003);
        wreg(3'd1, 2'd1, 16'hFFFE);
        wreg(3'd1, 2'd2, 16'h0005);
        wreg(3'd1, 2'd3, 16'h0010);
        wreg(3'd3, 2'd0, 16'h0100);
        wreg(3'd2, 2'd0, 16'h0008);
        wreg(3'd0, 2'd0, 16'h0100);
        wreg(3'd0, 2'd1, 16'hFFFE);
        wreg(3'd3, 2'd2, 16'h0200);
        wreg(3'd2, 2'd2, 16'h0005);
        wreg(3'd0, 2'd2, 16'h0201);
        wreg(3'd0, 2'd3, 16'h0040);

        // R10: readback of each kind
        rd_check("R10 page", 3'd4, 2'd3, 16'h0012);
        rd_check("R10 modify1", 3'd1, 2'd1, 16'hFFFE);
        rd_check("R10 length0", 3'd2, 2'd0, 16'h0008);
        rd_check("R10 base2", 3'd3, 2'd2, 16'h0200);
        rd_check("R10 unused code", 3'd6, 2'd0, 16'h0000);

        for (int v = 0; v < NVEC; v++) begin
            access($sformatf("R2/R3 vector %0d", v), VEC[v][28:27], VEC[v][26:25],
                   VEC[v][24], VEC[v][23:0]);
        end
        rd_check("R5 ptr2 after equal step", 3'd0, 2'd2, 16'h0202);
        rd_check("R4 ptr1 wrapped past 16 bits", 3'd0, 2'd1, 16'h0008);
        rd_check("R6 ptr0 after underflow", 3'd0, 2'd0, 16'h0106);
        rd_check("R7 page unchanged", 3'd4, 2'd0, 16'h0012);

        // R8: write and update of pointer 3 in one cycle
        wr_en = 1'b1; wr_kind = 3'd0; wr_sel = 2'd3; wr_data = 16'h0777;
        access("R8 address during collision", 2'd3, 2'd0, 1'b0, 24'h12004E);
        wr_en = 1'b0;
        rd_check("R8 write wins", 3'd0, 2'd3, 16'h0777);

        // R11: no valid, no update
        acc_ptr = 2'd3; acc_mod = 2'd0; acc_pre = 1'b0; acc_valid = 1'b0;
        @(posedge clk); #1;
        rd_check("R11 pointer held", 3'd0, 2'd3, 16'h0777);

        // R9: bank switch
        bank_sel = 1'b1;
        rd_check("R9 old bank until edge", 3'd0, 2'd0, 16'h0106);
        @(posedge clk); #1;
        rd_check("R9 bank1 index0", 3'd0, 2'd0, 16'h0000);
        rd_check("R9 bank1 page", 3'd4, 2'd0, 16'h0000);
        wreg(3'd0, 2'd0, 16'h0555);
        access("R9 bank1 address", 2'd0, 2'd0, 1'b0, 24'h000555);
        bank_sel = 1'b0;
        @(posedge clk); #1;
        rd_check("R9 bank0 index0 kept", 3'd0, 2'd0, 16'h0106);
        rd_check("R9 bank0 page kept", 3'd4, 2'd0, 16'h0012);
        bank_sel = 1'b1;
        @(posedge clk); #1;
        rd_check("R9 bank1 index0 kept", 3'd0, 2'd0, 16'h0555);

        // R1: reset again clears both banks
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        bank_sel = 1'b0;
        rd_check("R1 bank after reset", 3'd0, 2'd0, 16'h0000);
        rd_check("R1 page after reset", 3'd4, 2'd0, 16'h0000);
        @(posedge clk); #1;
        rd_check("R1 bank0 index2 cleared", 3'd0, 2'd2, 16'h0000);
        bank_sel = 1'b1;
        @(posedge clk); #1;
        rd_check("R1 bank1 index0 cleared", 3'd0, 2'd0, 16'h0000);

        finish_up();
    end
endmodule